// File: doc/BRIEF.md
# MSI-X Vector Table Register File

This block keeps the per-vector interrupt message table for a device that signals interrupts with messages. Each vector owns a 16-byte slot holding a 64-bit message address (two 32-bit words), a 32-bit message data word and a 32-bit vector control word. Software reaches the slots through a simple request bus. The bus carries a byte offset, a region select and an access size of 32 or 64 bits. The same bus also reaches a read-only window onto the pending bits, which an external dispatch engine supplies.

The block sends the stored address, the data and the per-vector mask bit to the dispatch engine. When a write clears a vector's mask bit, the block raises a one-cycle strobe carrying that vector's index. The engine can then deliver any message it was holding back. Reads return their data one clock after the request. Writes produce no response.

Top module: `msix_vec_regfile`

## Requirements
- R1: `req_size` 2'b10 is a 32-bit access and 2'b11 a 64-bit access. A read request gives `rsp_valid` high, with `rsp_rdata`, in the cycle after the request. A write request gives no `rsp_valid`. 32-bit read data sits in bits 31:0 with bits 63:32 zero.
- R2: In the table region (`req_region`=0), the vector index is offset/16. Inside a slot, offset 0x0 is the address low word, 0x4 the address high word, 0x8 the message data and 0xC the vector control. Each of these words can be written and read back with 32-bit accesses.
- R3: A 64-bit table access at slot offset 0x0 carries the address low word in bits 31:0 and the address high word in bits 63:32. At slot offset 0x8 it carries the message data in bits 31:0 and the vector control in bits 63:32.
- R4: After reset every address and data word is zero, every vector control word is 1, and `vec_mask` is all ones.
- R5: `vec_mask[i]` equals bit 0 of vector i's control word. `vec_addr[64i+63:64i]` is {address high, address low} and `vec_data[32i+31:32i]` is the message data.
- R6: A table read whose index is at or above NUM_VEC returns all ones at the access width. A table write to such an index changes nothing.
- R7: In the pending region (`req_region`=1), the word index is offset/8 and word w holds `pend_in` bits 64w..64w+63. Bits at or above NUM_VEC read as zero. A 32-bit read at offset 0 of a word gives bits 31:0 and at offset 4 gives bits 63:32. A word index at or above NUM_VEC/64+1 reads as all ones at the access width.
- R8: Writes to the pending region change no state.
- R9: An invalid size (2'b00, 2'b01) reads zero and writes nothing. A table access that is not aligned to 4 bytes (32-bit) or 8 bytes (64-bit) also reads zero and writes nothing. A pending access at a word offset other than 0 or 4 (32-bit) or other than 0 (64-bit) likewise reads zero and writes nothing.
- R10: A write that takes a vector's control bit 0 from 1 to 0 pulses `unmask_stb` for one cycle in the cycle after the write, with `unmask_idx` set to that vector. Any other write leaves `unmask_stb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 1 | 0 = vector table, 1 = pending window |
| req_size | input | 2 | Access size code |
| req_offset | input | OFF_W | Byte offset in the region |
| req_wdata | input | 64 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| vec_mask | output | NUM_VEC | Per-vector mask bits |
| vec_addr | output | 64*NUM_VEC | Per-vector message address |
| vec_data | output | 32*NUM_VEC | Per-vector message data |
| pend_in | input | NUM_VEC | Pending bits from the dispatch engine |
| unmask_stb | output | 1 | Mask cleared strobe |
| unmask_idx | output | $clog2(NUM_VEC) | Vector whose mask was cleared |

## Verification
The bench builds the block with NUM_VEC = 70. This gives two pending words, so the second word is only partly filled and its upper bits must read as zero. The third pending word is already out of range. A vector count that is not a power of two also means the table's upper limit falls inside the address space instead of at a wrap boundary. The last vector (69) and the first out-of-range index (70) are both exercised, in directed tests and by random offsets that run two slots past the end.

// File: rtl/msix_rf_pkg.sv
package msix_rf_pkg;

    typedef enum logic [1:0] {
        ACC_BAD = 2'd0,
        ACC_OOR = 2'd1,
        ACC_OK  = 2'd2
    } acc_kind_e;

    localparam logic [1:0] SZ_W32 = 2'b10;
    localparam logic [1:0] SZ_W64 = 2'b11;

    // word 0 addr low, 1 addr high, 2 message data, 3 vector control
    typedef logic [3:0][31:0] slot_t;

    localparam slot_t SLOT_RESET = '{32'd1, 32'd0, 32'd0, 32'd0};

endpackage

// File: rtl/msix_access_decode.sv
module msix_access_decode
    import msix_rf_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int OFF_W   = 16,
    parameter int IDX_W   = 5
) (
    input  logic             region_i,
    input  logic [1:0]       size_i,
    input  logic [OFF_W-1:0] offset_i,
    output acc_kind_e        kind_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [1:0]       word_o,
    output logic             wide_o
);
    localparam int PEND_WORDS = NUM_VEC / 64 + 1;

    logic [OFF_W-5:0] tbl_idx;
    logic [OFF_W-4:0] pnd_idx;
    logic             aligned;
    logic             in_range;
    logic             size_ok;

    assign tbl_idx = offset_i[OFF_W-1:4];
    assign pnd_idx = offset_i[OFF_W-1:3];
    assign size_ok = (size_i == SZ_W32) || (size_i == SZ_W64);
    assign wide_o  = (size_i == SZ_W64);

    always_comb begin
        if (region_i) begin
            in_range = int'(pnd_idx) < PEND_WORDS;
            aligned  = wide_o ? (offset_i[2:0] == 3'd0) : (offset_i[1:0] == 2'd0);
            word_o   = {1'b0, offset_i[2]};
            idx_o    = IDX_W'(pnd_idx);
        end else begin
            in_range = int'(tbl_idx) < NUM_VEC;
            aligned  = wide_o ? (offset_i[2:0] == 3'd0) : (offset_i[1:0] == 2'd0);
            word_o   = offset_i[3:2];
            idx_o    = IDX_W'(tbl_idx);
        end
        if (!size_ok)       kind_o = ACC_BAD;
        else if (!in_range) kind_o = ACC_OOR;
        else if (!aligned)  kind_o = ACC_BAD;
        else                kind_o = ACC_OK;
    end

endmodule

// File: rtl/msix_entry_slot.sv
module msix_entry_slot
    import msix_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_i,
    input  logic        wide_i,
    input  logic [1:0]  word_i,
    input  logic [63:0] wdata_i,
    output slot_t       slot_o,
    output logic        unmask_o
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (we_i) begin
            slot_d[word_i] = wdata_i[31:0];
            if (wide_i) slot_d[{word_i[1], 1'b1}] = wdata_i[63:32];
        end
        unmask_o = slot_q[3][0] & ~slot_d[3][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_RESET;
        else        slot_q <= slot_d;
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/msix_pend_view.sv
module msix_pend_view #(
    parameter int NUM_VEC = 16,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_VEC-1:0] pend_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               upper_i,
    input  logic               wide_i,
    output logic [63:0]        data_o
);
    localparam int PEND_WORDS = NUM_VEC / 64 + 1;
    localparam int PAD_BITS   = PEND_WORDS * 64;

    logic [PAD_BITS-1:0] padded;
    logic [63:0]         word;

    assign padded = PAD_BITS'(pend_i);

    always_comb begin
        word = '0;
        for (int w = 0; w < PEND_WORDS; w++) begin
            if (int'(idx_i) == w) word = padded[w*64 +: 64];
        end
        if (wide_i)       data_o = word;
        else if (upper_i) data_o = {32'd0, word[63:32]};
        else              data_o = {32'd0, word[31:0]};
    end

endmodule

// File: rtl/msix_vec_regfile.sv
module msix_vec_regfile
    import msix_rf_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int OFF_W   = 16,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int IDX_W  = $clog2(NUM_VEC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_region,
    input  logic [1:0]             req_size,
    input  logic [OFF_W-1:0]       req_offset,
    input  logic [63:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [63:0]            rsp_rdata,
    output logic [NUM_VEC-1:0]     vec_mask,
    output logic [64*NUM_VEC-1:0]  vec_addr,
    output logic [32*NUM_VEC-1:0]  vec_data,
    input  logic [NUM_VEC-1:0]     pend_in,
    output logic                   unmask_stb,
    output logic [VEC_W-1:0]       unmask_idx
);
    typedef struct packed {
        logic             rsp_valid;
        logic [63:0]      rsp_rdata;
        logic             stb;
        logic [VEC_W-1:0] stb_idx;
    } port_state_t;

    port_state_t st_d, st_q;

    acc_kind_e          dec_kind;
    logic [IDX_W-1:0]   dec_idx;
    logic [1:0]         dec_word;
    logic               dec_wide;
    logic [63:0]        pend_rd;
    logic               tbl_we;
    slot_t              slots [NUM_VEC];
    logic [NUM_VEC-1:0] slot_unmask;

    msix_access_decode #(
        .NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_decode (
        .region_i(req_region),
        .size_i  (req_size),
        .offset_i(req_offset),
        .kind_o  (dec_kind),
        .idx_o   (dec_idx),
        .word_o  (dec_word),
        .wide_o  (dec_wide)
    );

    msix_pend_view #(
        .NUM_VEC(NUM_VEC), .IDX_W(IDX_W)
    ) u_pend (
        .pend_i (pend_in),
        .idx_i  (dec_idx),
        .upper_i(dec_word[0]),
        .wide_i (dec_wide),
        .data_o (pend_rd)
    );

    assign tbl_we = req_valid && req_write && !req_region && (dec_kind == ACC_OK);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_slot
        msix_entry_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (tbl_we && (int'(dec_idx) == i)),
            .wide_i  (dec_wide),
            .word_i  (dec_word),
            .wdata_i (req_wdata),
            .slot_o  (slots[i]),
            .unmask_o(slot_unmask[i])
        );
        assign vec_mask[i]          = slots[i][3][0];
        assign vec_addr[i*64 +: 64] = {slots[i][1], slots[i][0]};
        assign vec_data[i*32 +: 32] = slots[i][2];
    end

    always_comb begin
        logic [63:0] rd;
        slot_t       sel;
        sel = SLOT_RESET;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (int'(dec_idx) == i) sel = slots[i];
        end
        rd = '0;
        case (dec_kind)
            ACC_OOR: rd = dec_wide ? '1 : 64'h0000_0000_FFFF_FFFF;
            ACC_OK: begin
                if (req_region)    rd = pend_rd;
                else if (dec_wide) rd = {sel[{dec_word[1], 1'b1}], sel[dec_word]};
                else               rd = {32'd0, sel[dec_word]};
            end
            default: rd = '0;
        endcase

        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        if (req_valid && !req_write) st_d.rsp_rdata = rd;
        st_d.stb       = |slot_unmask;
        st_d.stb_idx   = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (slot_unmask[i]) st_d.stb_idx = VEC_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign unmask_stb = st_q.stb;
    assign unmask_idx = st_q.stb_idx;

endmodule

// File: rtl/msix_vec_regfile_chk.sv
module msix_vec_regfile_chk #(
    parameter int NUM_VEC = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_region,
    input logic [1:0]            req_size,
    input logic                  rsp_valid,
    input logic [NUM_VEC-1:0]    vec_mask,
    input logic [64*NUM_VEC-1:0] vec_addr,
    input logic [32*NUM_VEC-1:0] vec_data,
    input logic                  unmask_stb
);
    // R1
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R1
    no_rsp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // R4
    reset_masked_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (&vec_mask));

    // R8
    pend_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_region)
        |=> ($stable(vec_mask) && $stable(vec_addr) && $stable(vec_data)));

    // R9
    bad_size_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_size[1])
        |=> ($stable(vec_mask) && $stable(vec_addr) && $stable(vec_data)));

    // R10
    unmask_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_stb |-> ($countones($past(vec_mask)) == $countones(vec_mask) + 1));

    // R10
    unmask_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_stb |=> !unmask_stb);

endmodule

bind msix_vec_regfile msix_vec_regfile_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_region(req_region),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .vec_mask  (vec_mask),
    .vec_addr  (vec_addr),
    .vec_data  (vec_data),
    .unmask_stb(unmask_stb)
);

// File: tb/msix_vec_regfile_bench.sv
`timescale 1ns/1ps
module msix_vec_regfile_bench;
    localparam int NV    = 70;
    localparam int OW    = 16;
    localparam int VW    = $clog2(NV);
    localparam int PWRDS = NV / 64 + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic                req_region = 1'b0;
    logic [1:0]          req_size = 2'b10;
    logic [OW-1:0]       req_offset = '0;
    logic [63:0]         req_wdata = '0;
    logic                rsp_valid;
    logic [63:0]         rsp_rdata;
    logic [NV-1:0]       vec_mask;
    logic [64*NV-1:0]    vec_addr;
    logic [32*NV-1:0]    vec_data;
    logic [NV-1:0]       pend_in = '0;
    logic                unmask_stb;
    logic [VW-1:0]       unmask_idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_w [NV][4];

    always #2.5 clk = ~clk;

    msix_vec_regfile #(.NUM_VEC(NV), .OFF_W(OW)) u_msix_vec_regfile (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // classify an access: 0 bad, 1 out of range, 2 ok
    function automatic int classify(input bit region, input logic [1:0] size, input int off);
        int lim, idx;
        if (size != 2'b10 && size != 2'b11) return 0;
        idx = region ? off / 8 : off / 16;
        lim = region ? PWRDS : NV;
        if (idx >= lim) return 1;
        if (size == 2'b11 && (off % 8) != 0) return 0;
        if (size == 2'b10 && (off % 4) != 0) return 0;
        return 2;
    endfunction

    function automatic logic [63:0] exp_read(input bit region, input logic [1:0] size, input int off);
        int c, idx, k;
        logic [127:0] pv;
        logic [63:0] w;
        c = classify(region, size, off);
        if (c == 0) return 64'd0;
        if (c == 1) return (size == 2'b11) ? '1 : 64'h0000_0000_FFFF_FFFF;
        if (region) begin
            pv = 128'(pend_in);
            w  = pv[(off / 8) * 64 +: 64];
            if (size == 2'b11) return w;
            return ((off % 8) == 4) ? {32'd0, w[63:32]} : {32'd0, w[31:0]};
        end
        idx = off / 16;
        k   = (off % 16) / 4;
        if (size == 2'b11) return {m_w[idx][k + 1], m_w[idx][k]};
        return {32'd0, m_w[idx][k]};
    endfunction

    task automatic model_write(input bit region, input logic [1:0] size, input int off,
                               input logic [63:0] wd, output bit stb, output int sidx);
        int idx, k;
        bit old_m;
        stb = 1'b0;
        sidx = 0;
        if (region || classify(region, size, off) != 2) return;
        idx = off / 16;
        k   = (off % 16) / 4;
        old_m = m_w[idx][3][0];
        m_w[idx][k] = wd[31:0];
        if (size == 2'b11) m_w[idx][k + 1] = wd[63:32];
        stb  = old_m && !m_w[idx][3][0];
        sidx = idx;
    endtask

    task automatic check_exports(input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (vec_mask[i] !== m_w[i][3][0]) ok = 1'b0;
            if (vec_addr[i*64 +: 64] !== {m_w[i][1], m_w[i][0]}) ok = 1'b0;
            if (vec_data[i*32 +: 32] !== m_w[i][2]) ok = 1'b0;
        end
        check(ok, {tag, " R5 exports"}, 64'(vec_mask), 64'd0);
    endtask

    task automatic do_read(input bit region, input logic [1:0] size, input int off, input string tag);
        logic [63:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_region = region;
        req_size = size; req_offset = OW'(off);
        e = exp_read(region, size, off);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, {tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_rdata === e, tag, rsp_rdata, e);
    endtask

    task automatic do_write(input bit region, input logic [1:0] size, input int off,
                            input logic [63:0] wd, input string tag);
        bit es;
        int ei;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_region = region;
        req_size = size; req_offset = OW'(off); req_wdata = wd;
        model_write(region, size, off, wd, es, ei);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b0, {tag, " R1 no rsp"}, 64'(rsp_valid), 64'd0);
        check(unmask_stb === es, {tag, " R10 stb"}, 64'(unmask_stb), 64'(es));
        if (es) check(int'(unmask_idx) == ei, {tag, " R10 idx"}, 64'(unmask_idx), 64'(ei));
        check_exports(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NV; i++) begin
            m_w[i][0] = '0; m_w[i][1] = '0; m_w[i][2] = '0; m_w[i][3] = 32'd1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        @(negedge clk);
        check(&vec_mask, "R4 mask all ones", 64'(vec_mask), '1);
        check_exports("R4");
        do_read(1'b0, 2'b10, 16'h000C, "R4 ctl reset");
        do_read(1'b0, 2'b10, 16'h0000, "R4 addr reset");

        // R2 single words, R3 pairing
        do_write(1'b0, 2'b10, 16'h0030, 64'h0, "R2 lo");
        do_write(1'b0, 2'b10, 16'h0030, 64'h1111_2222_DEAD_0004, "R2 lo");
        do_write(1'b0, 2'b10, 16'h0034, 64'h0000_0000_FEE0_0000, "R2 hi");
        do_write(1'b0, 2'b10, 16'h0038, 64'h0000_0000_0000_4321, "R2 data");
        do_read(1'b0, 2'b10, 16'h0034, "R2 hi readback");
        do_read(1'b0, 2'b11, 16'h0030, "R3 64b addr pair");
        do_write(1'b0, 2'b11, 16'h0038, 64'h0000_0000_0000_00AB, "R3 64b data+ctl unmask");
        do_read(1'b0, 2'b11, 16'h0038, "R3 64b data pair");
        do_write(1'b0, 2'b10, 16'h003C, 64'h0, "R10 0 to 0 no stb");
        do_write(1'b0, 2'b10, 16'h003C, 64'h1, "R10 0 to 1 no stb");
        do_write(1'b0, 2'b10, 16'h003C, 64'h2, "R10 1 to 0 stb");

        // last vector and first out-of-range index
        do_write(1'b0, 2'b10, (NV - 1) * 16 + 12, 64'h0, "R10 last vector");
        do_read(1'b0, 2'b10, NV * 16, "R6 oor 32");
        do_read(1'b0, 2'b11, NV * 16 + 8, "R6 oor 64");
        do_write(1'b0, 2'b11, NV * 16, 64'h0123_4567_89AB_CDEF, "R6 oor write dropped");

        // R7 pending window
        pend_in = '0;
        pend_in[0] = 1'b1; pend_in[40] = 1'b1; pend_in[65] = 1'b1; pend_in[NV-1] = 1'b1;
        do_read(1'b1, 2'b11, 0, "R7 word0 64");
        do_read(1'b1, 2'b10, 4, "R7 word0 upper");
        do_read(1'b1, 2'b11, 8, "R7 word1 partial");
        do_read(1'b1, 2'b10, 12, "R7 word1 upper zero");
        do_read(1'b1, 2'b10, 16, "R7 oor word");
        do_write(1'b1, 2'b11, 0, '1, "R8 pend write");
        do_write(1'b1, 2'b10, 16'h0030, '0, "R8 pend write table-like offset");

        // R9 invalid size and misalignment
        do_read(1'b0, 2'b01, 16'h0030, "R9 bad size read");
        do_write(1'b0, 2'b00, 16'h003C, 64'h1, "R9 bad size write");
        do_read(1'b0, 2'b10, 16'h0032, "R9 misaligned 32");
        do_read(1'b0, 2'b11, 16'h0034, "R9 misaligned 64");
        do_write(1'b0, 2'b11, 16'h0034, '1, "R9 misaligned write");
        do_read(1'b1, 2'b11, 4, "R9 pend misaligned 64");

        // random mix
        for (int n = 0; n < 600; n++) begin
            bit rg, wr;
            logic [1:0] sz;
            int off, r;
            logic [63:0] wd;
            if (n % 25 == 0) pend_in = NV'({$urandom, $urandom, $urandom});
            rg = ($urandom % 5) == 0;
            wr = ($urandom % 2) == 1;
            r  = $urandom % 20;
            sz = (r < 13) ? 2'b10 : (r < 19) ? 2'b11 : 2'(r % 2);
            off = rg ? int'($urandom % 32) : int'($urandom % ((NV + 2) * 16));
            if ($urandom % 8 != 0) off = (sz == 2'b11) ? (off & ~7) : (off & ~3);
            wd = {$urandom, $urandom};
            if (wr) do_write(rg, sz, off, wd, "R2 random write");
            else    do_read(rg, sz, off, "R7 R6 random read");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule